// File: doc/BRIEF.md
# Small RV32I Subset Processor

This block is a compact multi-cycle processor for a narrow slice of the RV32I base integer set. It covers register-immediate add, xor and or, word load and store, add-upper-immediate-to-pc, both unconditional jumps, and the environment call. Instructions and data share one internal byte-addressed RAM. Words are assembled little-endian with a synchronous read of one cycle. A byte-wide load port fills the RAM while reset is held.

Each instruction takes a fetch cycle and an execute cycle. A word load adds a third cycle that writes the returned data back. An environment call shows up at the ports as a one-cycle request pulse that carries the full value of a0. Register a7 selects the request: 10 means exit and 11 means print a character. Illegal encodings, misaligned jump targets and out-of-range data addresses each raise their own sticky fault flag and stop the core. The core also stops, with no fault, once the program counter leaves the code window.

Top module: `rv_mini_core`

## Requirements
- R1: While reset is held, halted, all three fault flags and both request pulses are low. After reset, execution starts at RAM_BASE. x2 starts at RAM_BASE + RAM_BYTES and every other register starts at zero.
- R2: x0 always reads zero. An instruction that targets x0 leaves it unchanged.
- R3: A word read from RAM takes the byte at the lowest address as bits 7:0 and the byte at the highest address as bits 31:24.
- R4: The 12-bit immediate in bits 31:20 is sign-extended from bit 31 before use.
- R5: Opcode 0010011 with funct3 000, 100 or 110 writes rd with rs1 plus, xor or or the immediate.
- R6: A store (opcode 0100011, funct3 010) writes rs2 to rs1 plus the split immediate. A load (opcode 0000011, funct3 010) from that address returns the same word.
- R7: Opcode 0010111 writes rd with the instruction's own address plus bits 31:12 shifted left by 12.
- R8: Opcode 1101111 writes the jump's address + 4 to rd and continues at the jump's address plus the sign-extended J-immediate.
- R9: Opcode 1100111 writes the jump's address + 4 to rd and continues at rs1 plus the I-immediate with bit 0 cleared. It never raises a fault.
- R10: A JAL whose target has bits 1:0 non-zero raises fault_misalign and halts without jumping.
- R11: Word 0x00100073 does nothing. Any other opcode-1110011 word is a call. With a7 = 11 it pulses env_putc for one cycle. With a7 = 10 it pulses env_exit and halts. Any other a7 value does nothing. During a pulse, env_arg holds a0.
- R12: An unsupported opcode, a load or store funct3 other than 010, or a register-immediate funct3 other than 000/100/110 raises fault_illegal and halts. No later instruction runs.
- R13: A load or store whose word does not lie wholly inside the RAM raises fault_access and halts. An access to the last word of RAM completes normally.
- R14: When the pc's offset from RAM_BASE reaches CODE_BYTES, the core halts with no fault. Once halted, it stays halted until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Byte write strobe for RAM preload, honoured only in reset |
| load_addr | input | $clog2(RAM_BYTES) | Byte offset written by the preload port |
| load_byte | input | 8 | Preload data |
| halted | output | 1 | Core has stopped |
| fault_illegal | output | 1 | Illegal instruction seen (sticky) |
| fault_misalign | output | 1 | Misaligned jump target (sticky) |
| fault_access | output | 1 | Data access outside RAM (sticky) |
| env_exit | output | 1 | One-cycle exit request |
| env_putc | output | 1 | One-cycle print-character request |
| env_arg | output | 32 | Value of a0 at the last request |

## Verification
The properties hold only when reset is applied and released cleanly, and only when the RAM contents and load port are settled before the core starts. The stimulus follows this rule: it writes every program and data word while reset is held, and only then releases reset. The one-cycle pulse and exclusivity properties rely on each call taking at least two cycles. The fault properties rely on exactly one error being detected per instruction. Each program ends in a call, a fault or a jump out of the code window, so every run reaches the halt state.

// File: rtl/rv_mini_core.sv
module rv_mini_core #(
  parameter logic [31:0] RAM_BASE   = 32'h8000_0000,
  parameter int          RAM_BYTES  = 1024,
  parameter int          CODE_BYTES = 512
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load_en,
  input  logic [$clog2(RAM_BYTES)-1:0] load_addr,
  input  logic [7:0]                   load_byte,
  output logic                         halted,
  output logic                         fault_illegal,
  output logic                         fault_misalign,
  output logic                         fault_access,
  output logic                         env_exit,
  output logic                         env_putc,
  output logic [31:0]                  env_arg
);
  localparam int          AW        = $clog2(RAM_BYTES);
  localparam logic [31:0] SP_INIT   = RAM_BASE + 32'(RAM_BYTES);
  localparam logic [31:0] LAST_WORD = 32'(RAM_BYTES - 4);
  localparam logic [31:0] CODE_LIM  = 32'(CODE_BYTES);
  localparam logic [6:0]  OP_IMM = 7'b0010011, OP_LD = 7'b0000011, OP_ST = 7'b0100011,
                          OP_AUI = 7'b0010111, OP_JAL = 7'b1101111, OP_JALR = 7'b1100111,
                          OP_SYS = 7'b1110011;

  typedef enum logic [1:0] {S_FETCH, S_EXEC, S_MEM, S_HALT} state_t;

  state_t      state;
  logic [7:0]  mem [RAM_BYTES];
  logic [31:0] rf  [32];
  logic [31:0] pc, rdata;
  logic [4:0]  ld_rd;

  wire [6:0]  opc = rdata[6:0];
  wire [4:0]  rd  = rdata[11:7];
  wire [2:0]  f3  = rdata[14:12];
  wire [4:0]  rs1 = rdata[19:15];
  wire [4:0]  rs2 = rdata[24:20];
  wire [31:0] imm_i = {{20{rdata[31]}}, rdata[31:20]};
  wire [31:0] imm_s = {{20{rdata[31]}}, rdata[31:25], rdata[11:7]};
  wire [31:0] imm_u = {rdata[31:12], 12'b0};
  wire [31:0] imm_j = {{11{rdata[31]}}, rdata[31], rdata[19:12], rdata[20], rdata[30:21], 1'b0};

  wire [31:0] a      = (rs1 == 5'd0) ? 32'd0 : rf[rs1];
  wire [31:0] b      = (rs2 == 5'd0) ? 32'd0 : rf[rs2];
  wire [31:0] ea     = a + ((opc == OP_ST) ? imm_s : imm_i);
  wire [31:0] ea_off = ea - RAM_BASE;
  wire        ea_bad = ea_off > LAST_WORD;
  wire [31:0] pc_off = pc - RAM_BASE;
  wire [31:0] link   = pc + 32'd4;
  wire [31:0] jal_t  = pc + imm_j;
  wire [31:0] jalr_t = (a + imm_i) & ~32'd1;
  wire [AW-1:0] maddr = (state == S_FETCH) ? pc_off[AW-1:0] : ea_off[AW-1:0];

  logic        wen, ill, mis, acc, to_mem, do_st, do_exit, do_putc;
  logic [31:0] wval, npc;

  always_comb begin
    wen = 1'b0; wval = '0; npc = link; ill = 1'b0; mis = 1'b0; acc = 1'b0;
    to_mem = 1'b0; do_st = 1'b0; do_exit = 1'b0; do_putc = 1'b0;
    case (opc)
      OP_IMM: begin
        wen = 1'b1;
        case (f3)
          3'b000:  wval = a + imm_i;
          3'b100:  wval = a ^ imm_i;
          3'b110:  wval = a | imm_i;
          default: begin wen = 1'b0; ill = 1'b1; end
        endcase
      end
      OP_LD:   if (f3 != 3'b010) ill = 1'b1; else if (ea_bad) acc = 1'b1; else to_mem = 1'b1;
      OP_ST:   if (f3 != 3'b010) ill = 1'b1; else if (ea_bad) acc = 1'b1; else do_st = 1'b1;
      OP_AUI:  begin wen = 1'b1; wval = pc + imm_u; end
      OP_JAL:  if (jal_t[1:0] != 2'b00) mis = 1'b1;
               else begin wen = 1'b1; wval = link; npc = jal_t; end
      OP_JALR: begin wen = 1'b1; wval = link; npc = jalr_t; end
      OP_SYS:  if (rdata != 32'h0010_0073) begin
                 do_exit = (rf[17] == 32'd10);
                 do_putc = (rf[17] == 32'd11);
               end
      default: ill = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    rdata <= {mem[maddr + AW'(3)], mem[maddr + AW'(2)], mem[maddr + AW'(1)], mem[maddr]};
    if (!rst_n && load_en)
      mem[load_addr] <= load_byte;
    else if (rst_n && state == S_EXEC && do_st)
      for (int k = 0; k < 4; k++) mem[ea_off[AW-1:0] + AW'(k)] <= b[8*k +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_FETCH; pc <= RAM_BASE; ld_rd <= '0; env_arg <= '0;
      env_exit <= 1'b0; env_putc <= 1'b0;
      fault_illegal <= 1'b0; fault_misalign <= 1'b0; fault_access <= 1'b0;
      for (int i = 0; i < 32; i++) rf[i] <= (i == 2) ? SP_INIT : 32'd0;
    end else begin
      env_exit <= 1'b0;
      env_putc <= 1'b0;
      case (state)
        S_FETCH: state <= (pc_off >= CODE_LIM) ? S_HALT : S_EXEC;
        S_EXEC: begin
          if (ill || mis || acc) begin
            state <= S_HALT;
            fault_illegal <= ill; fault_misalign <= mis; fault_access <= acc;
          end else begin
            if (wen && rd != 5'd0) rf[rd] <= wval;
            pc <= npc;
            ld_rd <= rd;
            env_exit <= do_exit;
            env_putc <= do_putc;
            if (do_exit || do_putc) env_arg <= rf[10];
            state <= to_mem ? S_MEM : (do_exit ? S_HALT : S_FETCH);
          end
        end
        S_MEM: begin
          if (ld_rd != 5'd0) rf[ld_rd] <= rdata;
          state <= S_FETCH;
        end
        default: state <= S_HALT;
      endcase
    end
  end

  assign halted = (state == S_HALT);
endmodule

// File: rtl/rv_mini_core_chk.sv
module rv_mini_core_chk (
  input logic clk,
  input logic rst_n,
  input logic halted,
  input logic fault_illegal,
  input logic fault_misalign,
  input logic fault_access,
  input logic env_exit,
  input logic env_putc
);
  // R10 R12 R13
  fault_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fault_illegal, fault_misalign, fault_access}));

  // R12
  fault_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_illegal || fault_misalign || fault_access) |-> halted);

  // R14
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  // R11
  exit_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    env_exit |-> halted);

  // R11
  env_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(env_exit && env_putc));

  // R11
  putc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    env_putc |=> !env_putc);
endmodule

bind rv_mini_core rv_mini_core_chk chk_i (
  .clk(clk), .rst_n(rst_n), .halted(halted),
  .fault_illegal(fault_illegal), .fault_misalign(fault_misalign), .fault_access(fault_access),
  .env_exit(env_exit), .env_putc(env_putc)
);

// File: tb/rv_mini_core_test.sv
module rv_mini_core_test;
  localparam int CLK_P = 10;
  localparam int AW = 10;
  localparam logic [31:0] BASE = 32'h8000_0000;
  localparam logic [6:0] OPI = 7'b0010011, LD = 7'b0000011, AUI = 7'b0010111, JR = 7'b1100111;
  localparam logic [31:0] ECALL = 32'h0000_0073, EBRK = 32'h0010_0073;

  logic clk = 1'b0, rst_n = 1'b0, load_en = 1'b0;
  logic [AW-1:0] load_addr = '0;
  logic [7:0] load_byte = '0;
  logic halted, fault_illegal, fault_misalign, fault_access, env_exit, env_putc;
  logic [31:0] env_arg;
  int checks = 0, fails = 0;

  bit          exq_kind[$];
  logic [31:0] exq_val[$];
  string       exq_req[$];

  rv_mini_core #(.RAM_BASE(BASE), .RAM_BYTES(1024), .CODE_BYTES(512)) uut (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr), .load_byte(load_byte),
    .halted(halted), .fault_illegal(fault_illegal), .fault_misalign(fault_misalign),
    .fault_access(fault_access), .env_exit(env_exit), .env_putc(env_putc), .env_arg(env_arg));

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [31:0] ei(int imm, int rs1, int f3, int rd, logic [6:0] op);
    return {imm[11:0], 5'(rs1), 3'(f3), 5'(rd), op};
  endfunction
  function automatic logic [31:0] es(int imm, int rs2, int rs1, int f3);
    return {imm[11:5], 5'(rs2), 5'(rs1), 3'(f3), imm[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] eu(int imm20, int rd, logic [6:0] op);
    return {imm20[19:0], 5'(rd), op};
  endfunction
  function automatic logic [31:0] ej(int imm, int rd);
    return {imm[20], imm[10:1], imm[11], imm[19:12], 5'(rd), 7'b1101111};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_env(bit is_exit, logic [31:0] v, string req);
    exq_kind.push_back(is_exit);
    exq_val.push_back(v);
    exq_req.push_back(req);
  endtask

  always @(negedge clk) begin
    if (rst_n && (env_exit || env_putc)) begin
      if (exq_val.size() == 0) begin
        checks++; fails++;
        $display("FAIL R11 actual=unexpected request arg=%h expected=none", env_arg);
      end else begin
        string r;
        bit k;
        logic [31:0] v;
        r = exq_req.pop_front();
        k = exq_kind.pop_front();
        v = exq_val.pop_front();
        check(r, {31'd0, env_exit}, {31'd0, k});
        check(r, env_arg, v);
      end
    end
  end

  task automatic put_byte(int off, logic [7:0] v);
    @(negedge clk);
    load_en = 1'b1; load_addr = AW'(off); load_byte = v;
  endtask

  task automatic put_word(int off, logic [31:0] w);
    for (int i = 0; i < 4; i++) put_byte(off + i, w[8*i +: 8]);
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic begin_test();
    @(negedge clk);
    rst_n = 1'b0;
    exq_kind.delete(); exq_val.delete(); exq_req.delete();
  endtask

  task automatic run_test(string req, logic [2:0] exp_flags);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 3000 && !halted; i++) @(negedge clk);
    repeat (2) @(negedge clk);
    check("R14", {31'd0, halted}, 32'd1);
    check(req, 32'(exq_val.size()), 32'd0);
    check(req, {29'd0, fault_illegal, fault_misalign, fault_access}, {29'd0, exp_flags});
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] bad [4];
    // R1: outputs during reset
    begin_test();
    repeat (2) @(negedge clk);
    check("R1", {26'd0, halted, fault_illegal, fault_misalign, fault_access, env_exit, env_putc}, 32'd0);

    // R1 R2 R4 R5 R7 R11
    put_word(0,  ei(0, 2, 0, 10, OPI));
    put_word(4,  ei(11, 0, 0, 17, OPI));
    put_word(8,  ECALL);
    put_word(12, ei(0, 5, 0, 10, OPI));
    put_word(16, ECALL);
    put_word(20, ei(5, 0, 0, 0, OPI));
    put_word(24, ei(0, 0, 0, 10, OPI));
    put_word(28, ECALL);
    put_word(32, ei(-5, 0, 0, 10, OPI));
    put_word(36, ei('hF0, 10, 4, 10, OPI));
    put_word(40, ECALL);
    put_word(44, ei('h123, 0, 0, 10, OPI));
    put_word(48, ei(-2048, 10, 6, 10, OPI));
    put_word(52, ECALL);
    put_word(56, eu('h12345, 10, AUI));
    put_word(60, ECALL);
    put_word(64, EBRK);
    put_word(68, ei(12, 0, 0, 17, OPI));
    put_word(72, ECALL);
    put_word(76, ei(10, 0, 0, 17, OPI));
    put_word(80, ei(7, 0, 0, 10, OPI));
    put_word(84, ECALL);
    expect_env(0, 32'h8000_0400, "R1");
    expect_env(0, 32'h0000_0000, "R1");
    expect_env(0, 32'h0000_0000, "R2");
    expect_env(0, 32'hFFFF_FF0B, "R4");
    expect_env(0, 32'hFFFF_F923, "R5");
    expect_env(0, 32'h9234_5038, "R7");
    expect_env(1, 32'h0000_0007, "R11");
    run_test("R11", 3'b000);

    // R3 R6 R13
    begin_test();
    put_byte('h200, 8'h11); put_byte('h201, 8'h22); put_byte('h202, 8'h33); put_byte('h203, 8'h44);
    put_word('h3FC, 32'hCAFE_F00D);
    put_word(0,  eu(0, 8, AUI));
    put_word(4,  ei('h200, 8, 0, 8, OPI));
    put_word(8,  ei(0, 8, 2, 10, LD));
    put_word(12, ei(11, 0, 0, 17, OPI));
    put_word(16, ECALL);
    put_word(20, ei(-1, 10, 4, 10, OPI));
    put_word(24, es(8, 10, 8, 2));
    put_word(28, ei(0, 0, 0, 10, OPI));
    put_word(32, ei(8, 8, 2, 10, LD));
    put_word(36, ECALL);
    put_word(40, ei('h1FC, 8, 2, 10, LD));
    put_word(44, ECALL);
    put_word(48, ei('h200, 8, 2, 10, LD));
    put_word(52, ECALL);
    expect_env(0, 32'h4433_2211, "R3");
    expect_env(0, 32'hBBCC_DDEE, "R6");
    expect_env(0, 32'hCAFE_F00D, "R13");
    run_test("R13", 3'b001);

    // R8 R9
    begin_test();
    put_word(0,  ei(11, 0, 0, 17, OPI));
    put_word(4,  ej(20, 1));
    put_word(8,  ei(0, 5, 0, 10, OPI));
    put_word(12, ECALL);
    put_word(16, ei(10, 0, 0, 17, OPI));
    put_word(20, ECALL);
    put_word(24, ei(0, 1, 0, 10, OPI));
    put_word(28, ECALL);
    put_word(32, ei(1, 1, 0, 5, JR));
    expect_env(0, 32'h8000_0008, "R8");
    expect_env(0, 32'h8000_0024, "R9");
    expect_env(1, 32'h8000_0024, "R9");
    run_test("R9", 3'b000);

    // R10 with forward and backward JAL first
    begin_test();
    put_word(0,  ej(32, 0));
    put_word(8,  ei(1, 0, 0, 10, OPI));
    put_word(12, ECALL);
    put_word(16, ej(6, 1));
    put_word(20, ECALL);
    put_word(32, ei(11, 0, 0, 17, OPI));
    put_word(36, ej(-28, 0));
    expect_env(0, 32'h0000_0001, "R8");
    run_test("R10", 3'b010);

    // R12
    bad[0] = ei(1, 0, 1, 10, OPI);
    bad[1] = 32'h0000_0533;
    bad[2] = ei(0, 0, 0, 10, LD);
    bad[3] = es(0, 10, 0, 0);
    for (int v = 0; v < 4; v++) begin
      begin_test();
      put_word(0,  ei(11, 0, 0, 17, OPI));
      put_word(4,  ei(2, 0, 0, 10, OPI));
      put_word(8,  ECALL);
      put_word(12, bad[v]);
      put_word(16, ECALL);
      expect_env(0, 32'h0000_0002, "R12");
      run_test("R12", 3'b100);
    end

    // R14
    begin_test();
    put_word(0,  ei(11, 0, 0, 17, OPI));
    put_word(4,  ei(3, 0, 0, 10, OPI));
    put_word(8,  ECALL);
    put_word(12, ej('h200 - 12, 0));
    put_word(16, ECALL);
    expect_env(0, 32'h0000_0003, "R14");
    run_test("R14", 3'b000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule